// File: doc/BRIEF.md
# Character Raster Timing Generator

This block generates the raster timing for a character-cell display. A horizontal character counter and a vertical scan-line and character-row counter step through the frame. From their positions the block derives horizontal sync, vertical sync, a display-enable window, a linear video memory address and the scan line within the current character row. The pixel fetch logic uses the address and row line to read glyph or bitmap data.

Its configuration sits in a 16-entry byte register file. A front end loads it through an index/data write port. Reset loads a fixed configuration: 57 character clocks per line, 128 character rows of 2 scan lines, 6 extra adjust lines (262 lines per frame), a visible window of 40 characters by 100 rows, and a start address of 0x1000. Writes take effect immediately; the counters compare against the live values.

Top module: `crt_timing_gen`

## Requirements
- R1: After a synchronous active-low reset the block sits at character 0 of scan line 0, with mem_addr = 0x1000. With the reset register values (index 0..15 = 38 28 2D 0A 7F 06 64 70 02 01 06 07 10 00 00 00 hex) a frame lasts 57 x 262 clocks and then repeats.
- R2: The character counter runs from 0 up to the value of register 0 and then returns to 0, so a scan line lasts register 0 + 1 clocks.
- R3: hsync is high when the character count c satisfies reg2 <= c < reg2 + (reg3 & 0x0F). The upper nibble of register 3 is ignored, and a low nibble of 0 gives no sync pulse.
- R4: row_addr counts 0..reg9 within each character row, and register 4 + 1 character rows make up the frame. Then come reg5 adjust lines, during which row_addr counts 0..reg5-1. A frame therefore has (reg4+1)*(reg9+1)+reg5 scan lines.
- R5: vsync is high for exactly 16 scan lines. Frame lines are numbered from 0, and the pulse starts at line reg7*(reg9+1), the first line of character row reg7.
- R6: disp_en is high only when the character count is below register 1, the character row is below register 6, and the line is not an adjust line.
- R7: mem_addr equals the row base plus the character count, modulo 2^14. The row base is {reg12[5:0], reg13} at frame start. It grows by register 1 after each completed character row, including the last one before the adjust lines.
- R8: A write with wr_en high stores wr_data into register wr_idx at the clock edge. Indices 0-7, 9, 12 and 13 are used. Writes to index 8 (interlace control) and to 10, 11, 14 and 15 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index |
| wr_data | input | 8 | Register write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Display-enable window |
| mem_addr | output | 14 | Linear video memory address |
| row_addr | output | 5 | Scan line within character row (or adjust line) |

## Verification
The embedded assertions check the counter stepping every cycle: character counter increment and wrap, row line increment and frame restart, and address increment and reload at line ends. They also check that a zero sync width never produces a horizontal pulse. Only the bench's sweeps can show the absolute frame geometry: the exact sync windows, the display window, the row-base arithmetic including 14-bit address wrap, frames without adjust lines, and the absence of any effect from the interlace and unused registers. The bench compares every output on every clock of whole frames under three register sets against values computed from frame position.

// File: rtl/crtc_pkg.sv
// Package: shared widths, register indices, configuration record and reset
// values for the character raster timing generator.
package crtc_pkg;

    localparam int CW   = 8;    // character/row counter and byte register width
    localparam int HSW  = 4;    // horizontal sync width field
    localparam int RAW  = 5;    // scan-line-in-row width
    localparam int MAW  = 14;   // memory address width
    localparam int LNW  = 14;   // frame scan-line counter width

    // Register indices decoded by the write port
    localparam logic [3:0] IX_HTOT  = 4'd0;
    localparam logic [3:0] IX_HDISP = 4'd1;
    localparam logic [3:0] IX_HSPOS = 4'd2;
    localparam logic [3:0] IX_HSWID = 4'd3;
    localparam logic [3:0] IX_VTOT  = 4'd4;
    localparam logic [3:0] IX_VADJ  = 4'd5;
    localparam logic [3:0] IX_VDISP = 4'd6;
    localparam logic [3:0] IX_VSROW = 4'd7;
    localparam logic [3:0] IX_MAXRA = 4'd9;
    localparam logic [3:0] IX_STHI  = 4'd12;
    localparam logic [3:0] IX_STLO  = 4'd13;

    localparam logic [MAW-1:0] RST_START = 14'h1000;

    typedef struct packed {
        logic [CW-1:0]  h_total;
        logic [CW-1:0]  h_disp;
        logic [CW-1:0]  hs_pos;
        logic [HSW-1:0] hs_width;
        logic [CW-1:0]  v_total;
        logic [RAW-1:0] v_adj;
        logic [CW-1:0]  v_disp;
        logic [CW-1:0]  vs_row;
        logic [RAW-1:0] max_ra;
        logic [MAW-1:0] start;
    } crtc_cfg_t;

    // Configuration loaded by reset
    function automatic crtc_cfg_t reset_cfg();
        crtc_cfg_t c;
        c.h_total  = 8'h38;
        c.h_disp   = 8'h28;
        c.hs_pos   = 8'h2D;
        c.hs_width = 4'hA;
        c.v_total  = 8'h7F;
        c.v_adj    = 5'h06;
        c.v_disp   = 8'h64;
        c.vs_row   = 8'h70;
        c.max_ra   = 5'h01;
        c.start    = RST_START;
        return c;
    endfunction

endpackage

// File: rtl/crtc_regfile.sv
// Module: crtc_regfile
// Holds the timing configuration written through an index/data port.
// Assumes one write per clock; only the fields that drive timing are kept,
// so writes to other indices (interlace and unused slots) are dropped.
module crtc_regfile
    import crtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  logic [3:0] idx,
    input  logic [7:0] data,
    output crtc_cfg_t cfg
);

    // Register update: reset to the fixed configuration, else decode index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= reset_cfg();
        end else if (we) begin
            case (idx)
                IX_HTOT:  cfg.h_total  <= data;
                IX_HDISP: cfg.h_disp   <= data;
                IX_HSPOS: cfg.hs_pos   <= data;
                IX_HSWID: cfg.hs_width <= data[HSW-1:0];
                IX_VTOT:  cfg.v_total  <= data;
                IX_VADJ:  cfg.v_adj    <= data[RAW-1:0];
                IX_VDISP: cfg.v_disp   <= data;
                IX_VSROW: cfg.vs_row   <= data;
                IX_MAXRA: cfg.max_ra   <= data[RAW-1:0];
                IX_STHI:  cfg.start[MAW-1:8] <= data[MAW-9:0];
                IX_STLO:  cfg.start[7:0]     <= data;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/crtc_hcount.sv
// Module: crtc_hcount
// Character counter for one scan line and horizontal sync window.
// Assumes the total may change at any time; the wrap uses >= so a count
// above a newly lowered total still returns to zero on the next clock.
module crtc_hcount #(
    parameter int CW  = 8,
    parameter int HSW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CW-1:0]  h_total,
    input  logic [CW-1:0]  hs_pos,
    input  logic [HSW-1:0] hs_width,
    output logic [CW-1:0]  h_cnt,
    output logic           line_end,
    output logic           hsync
);

    logic [CW:0] hs_stop;

    // Line end and sync window decode from the live count
    always_comb begin
        line_end = (h_cnt >= h_total);
        hs_stop  = (CW+1)'(hs_pos) + (CW+1)'(hs_width);
        hsync    = ((CW+1)'(h_cnt) >= (CW+1)'(hs_pos)) && ((CW+1)'(h_cnt) < hs_stop);
    end

    // Character counter: step every clock, wrap at line end
    always_ff @(posedge clk) begin
        if (!rst_n)        h_cnt <= '0;
        else if (line_end) h_cnt <= '0;
        else               h_cnt <= h_cnt + CW'(1);
    end

    AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (h_cnt == '0)); // R2
    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> (h_cnt == $past(h_cnt) + CW'(1))); // R2

endmodule

// File: rtl/crtc_vcount.sv
// Module: crtc_vcount
// Scan-line, character-row and adjust-line sequencing plus vertical sync.
// Assumes line_end pulses one clock per scan line. Adjust lines reuse the
// row-line counter; vsync is a fixed-length window on the frame line number.
module crtc_vcount #(
    parameter int CW     = 8,
    parameter int RAW    = 5,
    parameter int LNW    = 14,
    parameter int VS_LEN = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           line_end,
    input  logic [CW-1:0]  v_total,
    input  logic [RAW-1:0] v_adj,
    input  logic [RAW-1:0] max_ra,
    input  logic [CW-1:0]  vs_row,
    output logic [RAW-1:0] ra,
    output logic [CW-1:0]  row,
    output logic           in_adj,
    output logic           row_end,
    output logic           frame_end,
    output logic           vsync
);

    logic [LNW-1:0] line_no;
    logic [LNW-1:0] ra_span;
    logic [LNW-1:0] vs_start;
    logic [LNW-1:0] vs_stop;
    logic           row_last;
    logic           adj_last;

    // Row/frame boundary decode and vertical sync window
    always_comb begin
        row_last  = !in_adj && (ra >= max_ra);
        adj_last  = in_adj && (((RAW+1)'(ra) + (RAW+1)'(1)) >= (RAW+1)'(v_adj));
        row_end   = line_end && row_last;
        frame_end = line_end && (adj_last ||
                    (row_last && (row >= v_total) && (v_adj == '0)));
        ra_span   = LNW'(max_ra) + LNW'(1);
        vs_start  = LNW'(vs_row) * ra_span;
        vs_stop   = vs_start + LNW'(VS_LEN);
        vsync     = (line_no >= vs_start) && (line_no < vs_stop);
    end

    // Vertical sequencing: advance on each line end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_no <= '0;
            ra      <= '0;
            row     <= '0;
            in_adj  <= 1'b0;
        end else if (line_end) begin
            if (frame_end) begin
                line_no <= '0;
                ra      <= '0;
                row     <= '0;
                in_adj  <= 1'b0;
            end else begin
                line_no <= line_no + LNW'(1);
                if (row_last) begin
                    ra <= '0;
                    if (row >= v_total) in_adj <= 1'b1;
                    else                row    <= row + CW'(1);
                end else begin
                    ra <= ra + RAW'(1);
                end
            end
        end
    end

    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (line_no == '0 && ra == '0 && !in_adj && row == '0)); // R4
    AST_RA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !frame_end && !row_last) |=> (ra == $past(ra) + RAW'(1))); // R4

endmodule

// File: rtl/crtc_addrgen.sv
// Module: crtc_addrgen
// Linear memory address counter with a per-row base register.
// Assumes line/row/frame pulses from the counters; frame start has priority,
// a completed row moves the base on by the displayed width.
module crtc_addrgen #(
    parameter int CW  = 8,
    parameter int MAW = 14,
    parameter logic [MAW-1:0] RST_BASE = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           line_end,
    input  logic           row_end,
    input  logic           frame_end,
    input  logic [CW-1:0]  h_disp,
    input  logic [MAW-1:0] start,
    output logic [MAW-1:0] ma
);

    logic [MAW-1:0] row_base;
    logic [MAW-1:0] next_base;

    // Base of the following character row
    always_comb next_base = row_base + MAW'(h_disp);

    // Address and row-base update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_base <= RST_BASE;
            ma       <= RST_BASE;
        end else if (frame_end) begin
            row_base <= start;
            ma       <= start;
        end else if (row_end) begin
            row_base <= next_base;
            ma       <= next_base;
        end else if (line_end) begin
            ma       <= row_base;
        end else begin
            ma       <= ma + MAW'(1);
        end
    end

    AST_MA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> (ma == $past(ma) + MAW'(1))); // R7
    AST_MA_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !row_end && !frame_end) |=> (ma == $past(row_base))); // R7

endmodule

// File: rtl/crt_timing_gen.sv
// Module: crt_timing_gen (top)
// Character raster timing generator: register file, horizontal counter,
// vertical sequencer and address generator. Outputs are decoded from
// registered counter state, so they are glitch-free relative to clk.
module crt_timing_gen #(
    parameter int VSYNC_LINES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_idx,
    input  logic [7:0]  wr_data,
    output logic        hsync,
    output logic        vsync,
    output logic        disp_en,
    output logic [13:0] mem_addr,
    output logic [4:0]  row_addr
);
    import crtc_pkg::*;

    crtc_cfg_t      cfg;
    logic [CW-1:0]  h_cnt;
    logic [CW-1:0]  row;
    logic           line_end;
    logic           row_end;
    logic           frame_end;
    logic           in_adj;

    crtc_regfile u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_en),
        .idx  (wr_idx),
        .data (wr_data),
        .cfg  (cfg)
    );

    crtc_hcount #(.CW(CW), .HSW(HSW)) u_h (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_total (cfg.h_total),
        .hs_pos  (cfg.hs_pos),
        .hs_width(cfg.hs_width),
        .h_cnt   (h_cnt),
        .line_end(line_end),
        .hsync   (hsync)
    );

    crtc_vcount #(.CW(CW), .RAW(RAW), .LNW(LNW), .VS_LEN(VSYNC_LINES)) u_v (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_end (line_end),
        .v_total  (cfg.v_total),
        .v_adj    (cfg.v_adj),
        .max_ra   (cfg.max_ra),
        .vs_row   (cfg.vs_row),
        .ra       (row_addr),
        .row      (row),
        .in_adj   (in_adj),
        .row_end  (row_end),
        .frame_end(frame_end),
        .vsync    (vsync)
    );

    crtc_addrgen #(.CW(CW), .MAW(MAW), .RST_BASE(RST_START)) u_ma (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_end (line_end),
        .row_end  (row_end),
        .frame_end(frame_end),
        .h_disp   (cfg.h_disp),
        .start    (cfg.start),
        .ma       (mem_addr)
    );

    // Display window: visible column, visible row, not an adjust line
    always_comb disp_en = (h_cnt < cfg.h_disp) && (row < cfg.v_disp) && !in_adj;

    AST_NO_HS_ZERO_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.hs_width == '0) |-> !hsync); // R3
    AST_ADJ_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && in_adj) |=> !in_adj); // R4

endmodule

// File: tb/sim_crt_timing_gen.sv
// Bench: whole-frame sweeps under three register sets, expected outputs
// computed arithmetically from the frame position.
module sim_crt_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic        hsync, vsync, disp_en;
    logic [13:0] mem_addr;
    logic [4:0]  row_addr;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // Bench copy of the configuration, set from the requirements
    int b_ht, b_hd, b_hsp, b_hsw, b_vt, b_va, b_vd, b_vsr, b_mra, b_st;

    crt_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
        .mem_addr(mem_addr), .row_addr(row_addr)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic int frame_lines();
        return (b_vt + 1) * (b_mra + 1) + b_va;
    endfunction

    // Compare all outputs against the expected values at frame position p
    task automatic cmp_at(input int p, input string scen);
        int h, l, rl, row, ra, vs0;
        bit adj, e_hs, e_vs, e_de;
        int e_ma;
        h  = p % b_ht;
        l  = p / b_ht;
        rl = (b_vt + 1) * (b_mra + 1);
        adj = (l >= rl);
        if (!adj) begin
            row = l / (b_mra + 1);
            ra  = l % (b_mra + 1);
        end else begin
            row = b_vt + 1;
            ra  = l - rl;
        end
        vs0  = b_vsr * (b_mra + 1);
        e_hs = (h >= b_hsp) && (h < b_hsp + b_hsw);
        e_vs = (l >= vs0) && (l < vs0 + 16);
        e_de = (h < b_hd) && !adj && (row < b_vd);
        e_ma = (b_st + row * b_hd + h) % 16384;
        check(hsync == e_hs, "R3", {scen, " hsync"}, hsync, e_hs);
        check(vsync == e_vs, "R5", {scen, " vsync"}, vsync, e_vs);
        check(disp_en == e_de, "R6", {scen, " disp_en"}, disp_en, e_de);
        check(mem_addr == 14'(e_ma), "R7", {scen, " mem_addr"}, mem_addr, e_ma);
        check(row_addr == 5'(ra), "R4", {scen, " row_addr"}, row_addr, ra);
    endtask

    // Sweep n clocks starting at frame position p0, sampling at negedges
    task automatic sweep(input int n, input int p0, input string scen);
        int flen;
        flen = b_ht * frame_lines();
        for (int k = 0; k < n; k++) begin
            cmp_at((p0 + k) % flen, scen);
            @(negedge clk);
        end
    endtask

    task automatic wr(input int idx, input int data);
        wr_en   = 1'b1;
        wr_idx  = 4'(idx);
        wr_data = 8'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Wait until vsync has fallen, leaving the bench just after the fall
    task automatic wait_vs_fall();
        bit prev;
        prev = vsync;
        for (int k = 0; k < 40000; k++) begin
            @(negedge clk);
            if (prev && !vsync) break;
            prev = vsync;
        end
    endtask

    initial begin
        // Reset state (R1)
        repeat (3) @(negedge clk);
        check(mem_addr == 14'h1000, "R1", "reset mem_addr", mem_addr, 14'h1000);
        check(row_addr == 5'd0, "R1", "reset row_addr", row_addr, 0);
        check(hsync == 1'b0 && vsync == 1'b0, "R1", "reset syncs", {hsync, vsync}, 0);
        check(disp_en == 1'b1, "R1", "reset disp_en", disp_en, 1);

        // R1: default configuration, full frame plus one line of the next
        b_ht = 57; b_hd = 40; b_hsp = 45; b_hsw = 10; b_vt = 127; b_va = 6;
        b_vd = 100; b_vsr = 112; b_mra = 1; b_st = 'h1000;
        rst_n = 1'b1;
        sweep(57 * 262 + 57, 0, "R1 default");

        // R8: small set; index 3 upper nibble set, interlace and spare slots written
        wr(0, 9); wr(1, 6); wr(2, 7); wr(3, 'hF2); wr(4, 6); wr(5, 3);
        wr(6, 5); wr(7, 2); wr(9, 3); wr(12, 'h41); wr(13, 'h23);
        wr(8, 3); wr(10, 'hFF); wr(11, 'hFF); wr(14, 'hFF); wr(15, 'hFF);
        b_ht = 10; b_hd = 6; b_hsp = 7; b_hsw = 2; b_vt = 6; b_va = 3;
        b_vd = 5; b_vsr = 2; b_mra = 3; b_st = 'h123;
        wait_vs_fall();
        wait_vs_fall();
        sweep(2 * 10 * 31, (2 * 4 + 16) * 10, "R8 small");

        // R2 R4 R7: no adjust lines, zero sync width, address wrap at 2^14
        wr(0, 4); wr(1, 5); wr(2, 2); wr(3, 'h30); wr(4, 20); wr(5, 0);
        wr(6, 30); wr(7, 1); wr(9, 0); wr(12, 'h3F); wr(13, 'hFE);
        b_ht = 5; b_hd = 5; b_hsp = 2; b_hsw = 0; b_vt = 20; b_va = 0;
        b_vd = 30; b_vsr = 1; b_mra = 0; b_st = 'h3FFE;
        wait_vs_fall();
        wait_vs_fall();
        sweep(2 * 5 * 21, (1 + 16) * 5, "R2 wrap");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule